// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Page Write

This block is the byte-addressable front end of a small serial memory. It answers as a slave on a two-wire (I2C-style) bus over 128 bytes held in flip-flops. The bus clock and data lines are brought into the system clock domain through two-flop synchronizers. Bus transfers are recognized from edges of the synchronized lines. The data line is open-drain: the block can only pull it low or release it.

A transfer begins with a START, followed by a select byte that carries a 7-bit device address and a direction bit. A write then supplies one word-address byte and up to eight data bytes. The data bytes are buffered inside one aligned 8-byte page and are committed on STOP. After the commit, the block stays deaf to the bus for a programmable number of system clocks, which models the programming time. A read returns bytes starting at the current address counter. The counter steps through the whole array and continues until the master answers with a NACK. A random read is a write of the word address, then a repeated START and a read select.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset the data line is released and every memory byte reads back as 8'hFF.
- R2: A select byte is acknowledged only when its upper seven bits (bits 7..1, sent first) equal DEV_ADDR (default 7'h50). Bit 0 set to 1 means read and 0 means write. A select byte that does not match gets no ACK, and the block leaves the line released until the next START.
- R3: In a write, the byte after the select is always acknowledged. Its low seven bits load the address counter, and bit 7 is ignored.
- R4: In a write, each data byte is acknowledged and stored at the address counter. Only the low three address bits then advance, wrapping inside the 8-byte page. A ninth byte therefore overwrites the first.
- R5: In a read, bytes are sent MSB first, each starting at the address counter, which then advances and wraps from 127 to 0. A master ACK (line low in the ninth clock) requests the next byte.
- R6: After a master NACK (line high in the ninth clock), the block drives nothing until the next START.
- R7: A STOP that closes a write holding at least one data byte commits the page and starts a busy interval of WRITE_CYCLES system clocks. During that interval the block keeps the line released and acknowledges no select byte. After it, select bytes are acknowledged again.
- R8: A repeated START discards buffered write data without committing it. A STOP with no buffered data does not start a busy interval.
- R9: The block never pulls the line while the master is driving a data, address or acknowledge bit with the clock high.
- R10: The block changes its pull only after it has seen the clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume a well-formed bus. The clock and data lines are stable for many system clocks around each edge. The data line changes only while the clock is low, except for START and STOP. START and STOP never occur while the slave is pulling the line. The bench keeps every half bus period at twenty system clocks and sets data in the middle of the low phase. Every START and STOP is issued after the slave's acknowledge has been released.

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
  parameter int MEM_BYTES = 128,
  parameter int PAGE_BYTES = 8,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int WRITE_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = $clog2(WRITE_CYCLES + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_DEVSEL = 3'd1, S_ADDR = 3'd2,
                         S_WDATA = 3'd3, S_RDATA = 3'd4;

  logic [1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_q, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic [2:0] st, nxt;
  logic [3:0] rc;
  logic ack_ph;
  logic [7:0] shift, tx;
  logic [AW-1:0] addr;
  logic [BW-1:0] busy_cnt;
  logic busy, commit;
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvld;

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign busy = |busy_cnt;
  assign commit = stop_det & ~busy & (|pvld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (pvld[j]) mem[{addr[AW-1:PW], PW'(j)}] <= pbuf[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      st <= S_IDLE;
      nxt <= S_IDLE;
      rc <= 4'd0;
      ack_ph <= 1'b0;
      shift <= 8'd0;
      tx <= 8'd0;
      addr <= '0;
      busy_cnt <= '0;
      sda_pull_o <= 1'b0;
      pvld <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'd0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (busy) begin
        busy_cnt <= busy_cnt - BW'(1);
        st <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_det) begin
        st <= S_DEVSEL;
        rc <= 4'd0;
        ack_ph <= 1'b0;
        sda_pull_o <= 1'b0;
        pvld <= '0;
      end else if (stop_det) begin
        st <= S_IDLE;
        ack_ph <= 1'b0;
        sda_pull_o <= 1'b0;
        if (|pvld) begin
          busy_cnt <= BW'(WRITE_CYCLES);
          pvld <= '0;
        end
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (!ack_ph && rc != 4'd8) begin
            shift <= {shift[6:0], sda_s};
            rc <= rc + 4'd1;
          end else if (ack_ph && st == S_RDATA && sda_s) begin
            st <= S_IDLE;
          end
        end else if (scl_fall) begin
          if (!ack_ph && rc == 4'd8) begin
            ack_ph <= 1'b1;
            case (st)
              S_DEVSEL:
                if (shift[7:1] == DEV_ADDR) begin
                  sda_pull_o <= 1'b1;
                  nxt <= shift[0] ? S_RDATA : S_ADDR;
                end else begin
                  st <= S_IDLE;
                end
              S_ADDR: begin
                sda_pull_o <= 1'b1;
                addr <= shift[AW-1:0];
                nxt <= S_WDATA;
              end
              S_WDATA: begin
                sda_pull_o <= 1'b1;
                pbuf[addr[PW-1:0]] <= shift;
                pvld[addr[PW-1:0]] <= 1'b1;
                addr[PW-1:0] <= addr[PW-1:0] + PW'(1);
                nxt <= S_WDATA;
              end
              S_RDATA: begin
                sda_pull_o <= 1'b0;
                addr <= addr + AW'(1);
                nxt <= S_RDATA;
              end
              default: ;
            endcase
          end else if (ack_ph) begin
            ack_ph <= 1'b0;
            rc <= 4'd0;
            st <= nxt;
            if (nxt == S_RDATA) begin
              tx <= mem[addr];
              sda_pull_o <= ~mem[addr][7];
            end else begin
              sda_pull_o <= 1'b0;
            end
          end else if (st == S_RDATA) begin
            sda_pull_o <= ~tx[3'(4'd7 - rc)];
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_2w_slave_chk.sv
module eeprom_2w_slave_chk #(
  parameter int PGW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic pull,
  input logic scl_s,
  input logic busy,
  input logic [2:0] st,
  input logic [PGW-1:0] page
);
  // R10
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> $past(!scl_s));

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pull);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !pull);

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && $past(st) == 3'd3) |-> $stable(page));
endmodule

bind eeprom_2w_slave eeprom_2w_slave_chk #(.PGW(AW - PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pull(sda_pull_o), .scl_s(scl_s),
  .busy(busy), .st(st), .page(addr[AW-1:PW])
);

// File: tb/eeprom_2w_slave_tb.sv
`timescale 1ns/1ps
module eeprom_2w_slave_tb_top;
  localparam int WC = 600;
  localparam int H = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, pull, sda_bus;
  logic mst_own = 1'b0, done = 1'b0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [128];

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~pull;

  eeprom_2w_slave #(.WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(pull));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mst_own) chk("R9 slave quiet on master bit", pull, 0);

  task automatic hp(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start;
    sda_m = 1; hp(H/2); scl = 1; hp(H); sda_m = 0; hp(H); scl = 0;
  endtask
  task automatic bus_stop;
    hp(H/2); sda_m = 0; hp(H/2); scl = 1; hp(H); sda_m = 1; hp(H);
  endtask
  task automatic wbit(input logic b);
    hp(H/2); sda_m = b; hp(H/2); scl = 1; mst_own = 1; hp(H); mst_own = 0; scl = 0;
  endtask
  task automatic rbit(output logic b);
    hp(H/2); sda_m = 1; hp(H/2); scl = 1; hp(H/2); b = sda_bus; hp(H/2); scl = 0;
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(x);
    ack = ~x;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic last);
    logic x;
    for (int i = 7; i >= 0; i--) begin rbit(x); d[i] = x; end
    wbit(last);
  endtask

  task automatic page_write(input logic [7:0] abyte, input int n, input logic [7:0] base);
    logic ack;
    bus_start;
    wbyte(8'hA0, ack); chk("R2 select ack", ack, 1);
    wbyte(abyte, ack); chk("R3 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(base + 8'(i), ack); chk("R4 data ack", ack, 1);
      ref_mem[{abyte[6:3], 3'(abyte[2:0] + 3'(i))}] = base + 8'(i);
    end
    bus_stop;
  endtask

  task automatic rand_read(input logic [6:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start;
    wbyte(8'hA0, ack); chk({req, " select"}, ack, 1);
    wbyte({1'b0, a}, ack); chk({req, " address"}, ack, 1);
    bus_start;
    wbyte(8'hA1, ack); chk({req, " read select"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(d, (i == n - 1));
      chk(req, d, ref_mem[7'(a + 7'(i))]);
    end
    bus_stop;
  endtask

  initial begin
    logic ack, b;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
    hp(5); rst_n = 1; hp(5);
    chk("R1 line released after reset", pull, 0);
    rand_read(7'h10, 2, "R1 erased read");

    bus_start;
    wbyte(8'hA2, ack); chk("R2 foreign select nack", ack, 0);
    for (int i = 0; i < 8; i++) begin rbit(b); chk("R2 silent after mismatch", b, 1); end
    bus_stop;

    page_write(8'h8D, 3, 8'h11);
    bus_start;
    wbyte(8'hA0, ack); chk("R7 no ack while busy", ack, 0);
    bus_stop;
    hp(WC + 100);
    bus_start;
    wbyte(8'hA0, ack); chk("R7 ack after busy", ack, 1);
    bus_stop;
    rand_read(7'h0D, 3, "R3 R4 readback");

    page_write(8'h0D, 4, 8'h44);
    hp(WC + 100);
    rand_read(7'h08, 8, "R4 page wrap");

    page_write(8'h20, 9, 8'hA0);
    hp(WC + 100);
    rand_read(7'h20, 8, "R4 ninth byte overwrites");

    page_write(8'h7E, 2, 8'h5A);
    hp(WC + 100);
    page_write(8'h00, 1, 8'h3C);
    hp(WC + 100);
    rand_read(7'h7E, 3, "R5 sequential wrap");

    bus_start;
    wbyte(8'hA0, ack); wbyte(8'h7F, ack);
    bus_start;
    wbyte(8'hA1, ack); chk("R5 read select", ack, 1);
    rbyte(d, 1); chk("R5 single read", d, ref_mem[127]);
    for (int i = 0; i < 8; i++) begin rbit(b); chk("R6 silent after nack", b, 1); end
    bus_stop;

    bus_start;
    wbyte(8'hA0, ack); wbyte(8'h40, ack);
    wbyte(8'h99, ack); chk("R8 data ack", ack, 1);
    bus_start;
    wbyte(8'hA1, ack); chk("R8 read after repeated start", ack, 1);
    rbyte(d, 1); chk("R8 read at advanced address", d, ref_mem[8'h41]);
    bus_stop;
    bus_start;
    wbyte(8'hA0, ack); chk("R8 no busy without data", ack, 1);
    bus_stop;
    rand_read(7'h40, 1, "R8 discarded write");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule